// File: doc/BRIEF.md
# Transmit Character FIFO Front-End

This block is the transmit-side character buffer between a host parallel bus and a serial encoder. Each host write carries a 12-bit character bus and a data/command tag. The block shapes the write into a stored entry, masking the bits that the selected character width does not use. It then holds the entry in a 16-entry dual-clock FIFO. Writes arrive on the write clock and reads happen on the reference clock, and the two domains exchange Gray-coded pointers through two-flop synchronizers. On the read side, one entry is popped on each reference clock where the FIFO holds data and the downstream ready is high. When the FIFO is empty, a fill-request output is raised instead.

A static handshake-mode input selects how the host enable is timed. In pipeline-host mode, the character is taken on the same write-clock edge that samples the enable. In flag-driven-host mode, the host enable comes from another FIFO's flag, so the character is taken on the edge after the one that samples the enable. The same input also sets the active levels of the full, half-full and empty flags. A static bypass input removes the storage altogether. The host then writes in step with the reference clock, the write clock is ignored, and the character goes straight to the output register. With the half-rate setting, the full output becomes a strobe that toggles on every reference clock and marks the character slots in which a write is accepted.

Top module: `txf_top`

## Requirements
- R1: With `extFifoMode`=0, a write is stored with the `wrChar`/`wrCmd` values present at the same write-clock rising edge that samples `wrEn` high.
- R2: With `extFifoMode`=1, a write whose `wrEn` is sampled high at one write-clock edge stores the `wrChar`/`wrCmd` present at the next write-clock edge.
- R3: With `extFifoMode`=0, all three flags are active low: `fullFlag`=0 when 16 entries are held, `halfFlag`=0 when 8 or more are held, and `emptyFlag`=0 when none are held.
- R4: With `extFifoMode`=1, `fullFlag` and `emptyFlag` are active high and `halfFlag` is active low.
- R5: Half-full is active from 8 held entries upward and inactive at 7 or fewer.
- R6: A write attempted while full is active is dropped. The 16 stored entries still come out intact and in write order.
- R7: On each reference clock where the FIFO is non-empty and `rdReady` is 1, one entry is popped. `outValid` is 1 in the following cycle with that entry on `outChar`/`outCmd`, and entries leave in write order. While `rdReady` is 0, no entry leaves.
- R8: `fillReq` is 1 exactly when the FIFO is empty outside bypass, and it is 0 in bypass.
- R9: In encoded mode (`encBypass`=0), a stored character keeps bits [7:0] for data and [3:0] for a command when `byteWide`=1. When `byteWide`=0 it keeps [9:0] for data and [1:0] for a command. All other bits read 0, and `outCmd` equals `wrCmd`.
- R10: With `encBypass`=1, the character is raw: 10 bits ([9:0]) when `byteWide`=1 and all 12 bits when `byteWide`=0. `outCmd` is always 0.
- R11: With `bypassEn`=1, the write clock is ignored and writes are sampled on `refClk`. An accepted write shows on `outValid`/`outChar` one reference clock later, whatever the state of `rdReady`. `halfFlag` and `emptyFlag` sit at their inactive levels.
- R12: With `bypassEn`=1 and `halfRate`=1, `fullFlag` is a raw strobe that is 0 after reset and inverts on every `refClk` edge. A write is accepted only at an edge where `fullFlag` was 1 just before it. With `halfRate`=0, every edge accepts a write and `fullFlag` stays inactive.
- R13: `rstN` low empties the FIFO asynchronously, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock: read side, and the whole block in bypass |
| wrClk | input | 1 | Host write clock, unused in bypass |
| rstN | input | 1 | Asynchronous active-low reset |
| extFifoMode | input | 1 | Static: 1 = flag-driven host timing and flag levels, 0 = pipeline host |
| bypassEn | input | 1 | Static: 1 = no storage, writes on refClk |
| halfRate | input | 1 | Static: bypass character slot at half the reference rate |
| byteWide | input | 1 | Static: 1 = 8-bit/raw 10-bit characters, 0 = 10-bit/raw 12-bit |
| encBypass | input | 1 | Static: 1 = raw characters, no command tag |
| wrEn | input | 1 | Host write enable, active high |
| wrCmd | input | 1 | Host tag: 1 = command, 0 = data |
| wrChar | input | 12 | Host character bus |
| rdReady | input | 1 | Downstream can take an entry this reference clock |
| fullFlag | output | 1 | Full flag, or the slot strobe in half-rate bypass |
| halfFlag | output | 1 | Half-full flag, active low |
| emptyFlag | output | 1 | Empty flag, level set by extFifoMode |
| fillReq | output | 1 | FIFO empty, more characters wanted |
| outValid | output | 1 | An entry is presented this cycle |
| outCmd | output | 1 | Tag of the presented entry |
| outChar | output | 12 | Presented character |

## Verification
The collision that matters is a host write arriving at the full boundary while the read side has just started to pop. Because the freed slot takes two write clocks to cross the synchronizer, the write may still be dropped even though space exists. The bench provokes this by filling the FIFO with `rdReady` low and then raising `rdReady` while back-to-back writes continue. A model accepts a write only if the full flag is inactive at the falling edge before the write edge, and the drained stream is compared entry by entry against that model. A second coincidence appears in half-rate bypass, where an enable is held across both open and closed slots and only the open-slot characters may appear.

// File: rtl/txf_pkg.sv
`timescale 1ns/1ps
package txf_pkg;
  localparam int CHAR_W = 12;

  typedef struct packed {
    logic              isCmd;
    logic [CHAR_W-1:0] ch;
  } txEntry_t;

  typedef struct packed {
    logic push;   // write-clock domain: store wrEnt
    logic pop;    // reference domain: advance read pointer
    logic load;   // reference domain: bypass entry to output
  } txStrobe_t;

  typedef struct packed {
    logic fullRaw;
    logic halfRaw;
    logic emptyRaw;
  } txStatus_t;

  // Keep only the bits the selected character width uses.
  function automatic txEntry_t shapeEntry(input logic isCmd, input logic [CHAR_W-1:0] ch,
                                          input logic byteWide, input logic encBypass);
    txEntry_t e;
    logic [CHAR_W-1:0] keep;
    if (encBypass)      keep = byteWide ? CHAR_W'(12'h3FF) : {CHAR_W{1'b1}};
    else if (byteWide)  keep = isCmd ? CHAR_W'(12'h00F) : CHAR_W'(12'h0FF);
    else                keep = isCmd ? CHAR_W'(12'h003) : CHAR_W'(12'h3FF);
    e.isCmd = isCmd & ~encBypass;
    e.ch    = ch & keep;
    return e;
  endfunction
endpackage

// File: rtl/txf_sync2.sv
`timescale 1ns/1ps
module txf_sync2 #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/txf_capture.sv
`timescale 1ns/1ps
module txf_capture
  import txf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              extFifoMode,
  input  logic              en,
  input  logic              isCmd,
  input  logic [CHAR_W-1:0] ch,
  input  logic              byteWide,
  input  logic              encBypass,
  output logic              valid,
  output txEntry_t          ent
);
  logic enSeen;

  // Flag-driven host: the enable seen at one edge qualifies the bus at the next edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enSeen <= 1'b0;
    else       enSeen <= en;
  end

  always_comb begin
    valid = extFifoMode ? enSeen : en;
    ent   = shapeEntry(isCmd, ch, byteWide, encBypass);
  end
endmodule

// File: rtl/txf_ctrl.sv
`timescale 1ns/1ps
module txf_ctrl
  import txf_pkg::*;
(
  input  logic              wrClk,
  input  logic              refClk,
  input  logic              rstN,
  input  logic              extFifoMode,
  input  logic              bypassEn,
  input  logic              halfRate,
  input  logic              byteWide,
  input  logic              encBypass,
  input  logic              wrEn,
  input  logic              wrCmd,
  input  logic [CHAR_W-1:0] wrChar,
  input  logic              rdReady,
  input  txStatus_t         stat,
  output txStrobe_t         strb,
  output txEntry_t          wrEnt,
  output txEntry_t          bypEnt,
  output logic              fullFlag,
  output logic              halfFlag,
  output logic              emptyFlag,
  output logic              fillReq
);
  logic wrValid, refValid;
  logic slotTgl, slotOpen;
  logic fullAct, halfAct, emptyAct;

  // Same capture logic instanced once per clock domain, so no clock mux is needed.
  txf_capture uCapWr (
    .clk(wrClk), .rstN(rstN), .extFifoMode(extFifoMode), .en(wrEn),
    .isCmd(wrCmd), .ch(wrChar), .byteWide(byteWide), .encBypass(encBypass),
    .valid(wrValid), .ent(wrEnt)
  );

  txf_capture uCapRef (
    .clk(refClk), .rstN(rstN), .extFifoMode(extFifoMode), .en(wrEn),
    .isCmd(wrCmd), .ch(wrChar), .byteWide(byteWide), .encBypass(encBypass),
    .valid(refValid), .ent(bypEnt)
  );

  // Character slot strobe for half-rate bypass.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                     slotTgl <= 1'b0;
    else if (bypassEn && halfRate) slotTgl <= ~slotTgl;
    else                           slotTgl <= 1'b0;
  end

  always_comb begin
    slotOpen  = halfRate ? slotTgl : 1'b1;
    strb.push = wrValid & ~bypassEn & ~stat.fullRaw;
    strb.pop  = ~bypassEn & ~stat.emptyRaw & rdReady;
    strb.load = bypassEn & refValid & slotOpen;

    fullAct   = ~bypassEn & stat.fullRaw;
    halfAct   = ~bypassEn & stat.halfRaw;
    emptyAct  = ~bypassEn & stat.emptyRaw;

    if (bypassEn && halfRate) fullFlag = slotTgl;
    else                      fullFlag = extFifoMode ? fullAct : ~fullAct;
    halfFlag  = ~halfAct;
    emptyFlag = extFifoMode ? emptyAct : ~emptyAct;
    fillReq   = emptyAct;
  end

  // R12: the slot strobe changes level on every reference edge in half-rate bypass
  p_full_strobe_r12: assert property (@(posedge refClk) disable iff (!rstN)
    (bypassEn && halfRate) |=> (fullFlag != $past(fullFlag)));
endmodule

// File: rtl/txf_datapath.sv
`timescale 1ns/1ps
module txf_datapath
  import txf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      wrClk,
  input  logic      refClk,
  input  logic      rstN,
  input  txStrobe_t strb,
  input  txEntry_t  wrEnt,
  input  txEntry_t  bypEnt,
  output txStatus_t stat,
  output logic      outValid,
  output txEntry_t  outEnt
);
  localparam int ADDR_W    = $clog2(DEPTH);
  localparam int PTR_W     = ADDR_W + 1;
  localparam int HALF_MARK = DEPTH / 2;

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  txEntry_t         mem [DEPTH];
  logic [PTR_W-1:0] wBin, wGray, rBin, rGray;
  logic [PTR_W-1:0] rGraySyncW, wGraySyncR;
  logic [PTR_W-1:0] occW;

  // Write domain
  always_ff @(posedge wrClk) begin
    if (strb.push) mem[wBin[ADDR_W-1:0]] <= wrEnt;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wBin  <= '0;
      wGray <= '0;
    end else if (strb.push) begin
      wBin  <= wBin + 1'b1;
      wGray <= toGray(wBin + 1'b1);
    end
  end

  txf_sync2 #(.W(PTR_W)) uSyncToWr (.clk(wrClk), .rstN(rstN), .d(rGray), .q(rGraySyncW));
  txf_sync2 #(.W(PTR_W)) uSyncToRd (.clk(refClk), .rstN(rstN), .d(wGray), .q(wGraySyncR));

  always_comb begin
    occW          = wBin - fromGray(rGraySyncW);
    stat.fullRaw  = (occW >= PTR_W'(DEPTH));
    stat.halfRaw  = (occW >= PTR_W'(HALF_MARK));
    stat.emptyRaw = (rGray == wGraySyncR);
  end

  // Read domain
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      rBin  <= '0;
      rGray <= '0;
    end else if (strb.pop) begin
      rBin  <= rBin + 1'b1;
      rGray <= toGray(rBin + 1'b1);
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outEnt   <= '0;
    end else begin
      outValid <= strb.pop | strb.load;
      if (strb.pop)       outEnt <= mem[rBin[ADDR_W-1:0]];
      else if (strb.load) outEnt <= bypEnt;
    end
  end

  // R7: the controller never pops a FIFO the read side sees as empty
  p_pop_nonempty_r7: assert property (@(posedge refClk) disable iff (!rstN)
    strb.pop |-> !stat.emptyRaw);
  // R7: read pointer holds when no pop is issued
  p_ptr_hold_r7: assert property (@(posedge refClk) disable iff (!rstN)
    !strb.pop |=> $stable(rBin));
  // R6: occupancy never exceeds the depth
  p_no_overflow_r6: assert property (@(posedge wrClk) disable iff (!rstN)
    occW <= PTR_W'(DEPTH));
  // R6: a full FIFO keeps its write pointer across the next edge
  p_wr_hold_r6: assert property (@(posedge wrClk) disable iff (!rstN)
    stat.fullRaw |=> (wBin == $past(wBin)));
endmodule

// File: rtl/txf_top.sv
`timescale 1ns/1ps
module txf_top
  import txf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              refClk,
  input  logic              wrClk,
  input  logic              rstN,
  input  logic              extFifoMode,
  input  logic              bypassEn,
  input  logic              halfRate,
  input  logic              byteWide,
  input  logic              encBypass,
  input  logic              wrEn,
  input  logic              wrCmd,
  input  logic [CHAR_W-1:0] wrChar,
  input  logic              rdReady,
  output logic              fullFlag,
  output logic              halfFlag,
  output logic              emptyFlag,
  output logic              fillReq,
  output logic              outValid,
  output logic              outCmd,
  output logic [CHAR_W-1:0] outChar
);
  txStrobe_t strb;
  txStatus_t stat;
  txEntry_t  wrEnt, bypEnt, outEnt;

  txf_ctrl uCtrl (
    .wrClk(wrClk), .refClk(refClk), .rstN(rstN),
    .extFifoMode(extFifoMode), .bypassEn(bypassEn), .halfRate(halfRate),
    .byteWide(byteWide), .encBypass(encBypass),
    .wrEn(wrEn), .wrCmd(wrCmd), .wrChar(wrChar), .rdReady(rdReady),
    .stat(stat), .strb(strb), .wrEnt(wrEnt), .bypEnt(bypEnt),
    .fullFlag(fullFlag), .halfFlag(halfFlag), .emptyFlag(emptyFlag), .fillReq(fillReq)
  );

  txf_datapath #(.DEPTH(DEPTH)) uData (
    .wrClk(wrClk), .refClk(refClk), .rstN(rstN),
    .strb(strb), .wrEnt(wrEnt), .bypEnt(bypEnt),
    .stat(stat), .outValid(outValid), .outEnt(outEnt)
  );

  assign outCmd  = outEnt.isCmd;
  assign outChar = outEnt.ch;

  // R12: in half-rate bypass, outputs never come in two adjacent cycles
  p_byp_gap_r12: assert property (@(posedge refClk) disable iff (!rstN)
    (bypassEn && halfRate && outValid) |=> !outValid);
  // R5: with active-low flags, full implies half-full
  p_half_with_full_r5: assert property (@(posedge wrClk) disable iff (!rstN)
    (!bypassEn && !extFifoMode && !fullFlag) |-> !halfFlag);
endmodule

// File: tb/tb_txf_top.sv
`timescale 1ns/1ps
module tb_txf_top;
  logic        refClk = 1'b0;
  logic        wrClk = 1'b0;
  bit          wrClkOn = 1'b1;
  logic        rstN, extFifoMode, bypassEn, halfRate, byteWide, encBypass;
  logic        wrEn, wrCmd, rdReady;
  logic [11:0] wrChar;
  logic        fullFlag, halfFlag, emptyFlag, fillReq, outValid, outCmd;
  logic [11:0] outChar;

  int nChecks = 0;
  int nErr = 0;
  logic [12:0] expQ[$];
  logic [12:0] gotQ[$];

  always #4 refClk = ~refClk;            // 125 MHz
  always #5 if (wrClkOn) wrClk = ~wrClk; // host clock, unrelated rate

  txf_top dut (
    .refClk(refClk), .wrClk(wrClk), .rstN(rstN),
    .extFifoMode(extFifoMode), .bypassEn(bypassEn), .halfRate(halfRate),
    .byteWide(byteWide), .encBypass(encBypass),
    .wrEn(wrEn), .wrCmd(wrCmd), .wrChar(wrChar), .rdReady(rdReady),
    .fullFlag(fullFlag), .halfFlag(halfFlag), .emptyFlag(emptyFlag), .fillReq(fillReq),
    .outValid(outValid), .outCmd(outCmd), .outChar(outChar)
  );

  always @(negedge refClk) if (rstN === 1'b1 && outValid === 1'b1) gotQ.push_back({outCmd, outChar});

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic ext, input logic byp, input logic hr, input logic bw, input logic eb);
    @(negedge refClk);
    rstN = 1'b0;
    extFifoMode = ext; bypassEn = byp; halfRate = hr; byteWide = bw; encBypass = eb;
    wrEn = 1'b0; wrCmd = 1'b0; wrChar = '0; rdReady = 1'b0;
    repeat (3) @(negedge refClk);
    rstN = 1'b1;
    expQ.delete(); gotQ.delete();
    repeat (2) @(negedge refClk);
  endtask

  // Back-to-back pipeline-mode writes; accepted when full reads inactive before the edge.
  task automatic streamPipe(input int n, input logic [11:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      wrEn = 1'b1; wrCmd = 1'b0; wrChar = base + 12'(i);
      if (fullFlag === 1'b1) expQ.push_back({1'b0, base + 12'(i)});
    end
    @(negedge wrClk);
    wrEn = 1'b0;
  endtask

  // Flag-driven host: enable one cycle, character on the next.
  task automatic pushExt(input logic [11:0] ch);
    @(negedge wrClk);
    wrEn = 1'b1; wrCmd = 1'b0; wrChar = 12'h0EE;
    @(negedge wrClk);
    wrEn = 1'b0; wrChar = ch;
    if (fullFlag === 1'b0) expQ.push_back({1'b0, ch});
    @(negedge wrClk);
    wrChar = 12'h0DD;
  endtask

  task automatic drainCmp(input string req);
    rdReady = 1'b1;
    for (int i = 0; i < 400 && gotQ.size() < expQ.size(); i++) @(negedge refClk);
    repeat (6) @(negedge refClk);
    chk(req, "entry count", gotQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
      chk(req, $sformatf("entry %0d", i), gotQ[i], expQ[i]);
    expQ.delete(); gotQ.delete();
  endtask

  task automatic t_reset();
    cfg(0, 0, 0, 1, 0);
    chk("R3", "full idle pipeline", fullFlag, 1);
    chk("R3", "half idle pipeline", halfFlag, 1);
    chk("R3", "empty idle pipeline", emptyFlag, 0);
    chk("R8", "fillReq when empty", fillReq, 1);
    chk("R7", "outValid idle", outValid, 0);
    cfg(1, 0, 0, 1, 0);
    chk("R4", "full idle ext", fullFlag, 0);
    chk("R4", "half idle ext", halfFlag, 1);
    chk("R4", "empty idle ext", emptyFlag, 1);
  endtask

  task automatic t_timing();
    cfg(0, 0, 0, 1, 0);
    @(negedge wrClk); wrEn = 1'b1; wrChar = 12'h0A1;
    @(negedge wrClk); wrEn = 1'b0; wrChar = 12'h0B2;
    @(negedge wrClk); wrChar = 12'h000;
    expQ.push_back({1'b0, 12'h0A1});
    drainCmp("R1");
    cfg(1, 0, 0, 1, 0);
    @(negedge wrClk); wrEn = 1'b1; wrChar = 12'h0A1;
    @(negedge wrClk); wrEn = 1'b0; wrChar = 12'h0B2;
    @(negedge wrClk); wrChar = 12'h000;
    expQ.push_back({1'b0, 12'h0B2});
    drainCmp("R2");
  endtask

  task automatic t_fill();
    cfg(0, 0, 0, 1, 0);
    streamPipe(7, 12'h010);
    chk("R5", "half at 7 entries", halfFlag, 1);
    streamPipe(1, 12'h017);
    chk("R5", "half at 8 entries", halfFlag, 0);
    streamPipe(8, 12'h018);
    chk("R3", "full at 16 entries", fullFlag, 0);
    repeat (4) @(negedge refClk);
    chk("R3", "empty with data", emptyFlag, 1);
    chk("R8", "fillReq with data", fillReq, 0);
    streamPipe(2, 12'h0F0);
    chk("R6", "model held 16", expQ.size(), 16);
    drainCmp("R6");
    chk("R8", "fillReq after drain", fillReq, 1);

    cfg(1, 0, 0, 1, 0);
    for (int i = 0; i < 16; i++) pushExt(12'h040 + 12'(i));
    chk("R4", "full active high", fullFlag, 1);
    chk("R4", "half active low", halfFlag, 0);
    repeat (4) @(negedge refClk);
    chk("R4", "empty low with data", emptyFlag, 0);
    drainCmp("R4");
    chk("R4", "empty high after drain", emptyFlag, 1);
  endtask

  task automatic fmtCase(input logic bw, input logic eb, input logic cmd, input logic [12:0] expE, input string req);
    cfg(0, 0, 0, bw, eb);
    @(negedge wrClk); wrEn = 1'b1; wrCmd = cmd; wrChar = 12'hFFF;
    @(negedge wrClk); wrEn = 1'b0; wrCmd = 1'b0;
    expQ.push_back(expE);
    drainCmp(req);
  endtask

  task automatic t_format();
    fmtCase(1, 0, 0, 13'h00FF, "R9");
    fmtCase(1, 0, 1, 13'h100F, "R9");
    fmtCase(0, 0, 0, 13'h03FF, "R9");
    fmtCase(0, 0, 1, 13'h1003, "R9");
    fmtCase(1, 1, 1, 13'h03FF, "R10");
    fmtCase(0, 1, 1, 13'h0FFF, "R10");
  endtask

  task automatic t_stall_collide();
    cfg(0, 0, 0, 1, 0);
    streamPipe(3, 12'h020);
    repeat (10) @(negedge refClk);
    chk("R7", "no output while not ready", gotQ.size(), 0);
    drainCmp("R7");
    // Fill, then start reading while writes continue at the full boundary.
    cfg(0, 0, 0, 1, 0);
    streamPipe(16, 12'h080);
    rdReady = 1'b1;
    streamPipe(24, 12'h0A0);
    drainCmp("R6");
  endtask

  task automatic t_bypass();
    logic prevFull;
    wrClkOn = 1'b0;
    cfg(0, 1, 1, 0, 0);
    chk("R11", "empty inactive in bypass", emptyFlag, 1);
    chk("R11", "half inactive in bypass", halfFlag, 1);
    chk("R8", "fillReq low in bypass", fillReq, 0);
    prevFull = fullFlag;
    for (int i = 0; i < 8; i++) begin
      @(negedge refClk);
      chk("R12", "slot strobe alternates", fullFlag, !prevFull);
      prevFull = fullFlag;
      wrEn = 1'b1; wrChar = 12'h100 + 12'(i);
      if (fullFlag === 1'b1) expQ.push_back({1'b0, 12'h100 + 12'(i)});
    end
    @(negedge refClk); wrEn = 1'b0;
    repeat (3) @(negedge refClk);
    chk("R12", "open slots accepted", expQ.size(), 4);
    chk("R12", "bypass count", gotQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
      chk("R12", $sformatf("bypass entry %0d", i), gotQ[i], expQ[i]);

    cfg(0, 1, 0, 0, 0);
    @(negedge refClk); wrEn = 1'b1; wrChar = 12'h2AB;
    @(negedge refClk); wrEn = 1'b0;
    chk("R11", "bypass latency valid", outValid, 1);
    chk("R11", "bypass latency char", outChar, 12'h2AB);
    chk("R12", "full inactive full rate", fullFlag, 1);
    @(negedge refClk);
    chk("R11", "single output", outValid, 0);
    gotQ.delete();
    for (int i = 0; i < 5; i++) begin
      @(negedge refClk); wrEn = 1'b1; wrChar = 12'h300 + 12'(i);
      expQ.push_back({1'b0, 12'h300 + 12'(i)});
    end
    @(negedge refClk); wrEn = 1'b0;
    repeat (3) @(negedge refClk);
    chk("R12", "every edge accepts", gotQ.size(), 5);
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
      chk("R11", $sformatf("full-rate entry %0d", i), gotQ[i], expQ[i]);
    wrClkOn = 1'b1;
  endtask

  task automatic t_async_reset();
    cfg(0, 0, 0, 1, 0);
    streamPipe(3, 12'h030);
    repeat (4) @(negedge refClk);
    chk("R13", "not empty before reset", emptyFlag, 1);
    #1 rstN = 1'b0;
    #1 chk("R13", "empty without clock edge", emptyFlag, 0);
    chk("R13", "full cleared", fullFlag, 1);
    repeat (2) @(negedge refClk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    nChecks++; nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; extFifoMode = 1'b0; bypassEn = 1'b0; halfRate = 1'b0;
    byteWide = 1'b1; encBypass = 1'b0; wrEn = 1'b0; wrCmd = 1'b0; wrChar = '0; rdReady = 1'b0;
    t_reset();
    t_timing();
    t_fill();
    t_format();
    t_stall_collide();
    t_bypass();
    t_async_reset();
    finishRun();
  end
endmodule